// File: doc/BRIEF.md
# Offset Calibration and Power-Down Sequencer

This block sits between a decimation stage and a serial transmitter in a multi-channel audio converter. Every sample-rate strobe brings one 20-bit two's-complement sample per channel. It returns each sample with a stored per-channel DC offset subtracted from it, clamped to the 20-bit range, one clock after the strobe.

An active-low power-down input controls the block. While that input is low, the block reports power-down and asks the serial transmitter to stay quiet. When the input goes high again after a low pulse long enough to qualify, and calibration is enabled, a measurement cycle starts. The input is assumed to be at zero during this cycle. For 4096 sample periods every channel's samples are summed, and the average becomes the new offset. During the cycle the busy flag is high and every output sample is zero. One further quiet sample period follows, and then corrected data resumes.

When calibration is disabled, releasing the power-down input returns the block straight to normal running, and no offset is subtracted. A low pulse that is too short to qualify is treated as noise and does not start a calibration.

Top module: `ofc_cal_seq`

## Requirements
- R1: While `rst` is high, and on the cycle after it, all outputs are zero.
- R2: One clock after `pdn_n` is sampled low, `pwr_down` and `mute` are high and `cal_busy` is low. Every strobe taken while in power-down yields all-zero output data.
- R3: If `pdn_n` is sampled low on 2 or fewer consecutive edges before returning high, no calibration starts. The next strobe yields corrected, non-zero data.
- R4: If `pdn_n` is sampled low on 3 or more edges, returns high, and `cal_en_n` is low, then `cal_busy` and `mute` are high one clock later. This is within the limit of 6 clocks.
- R5: A calibration spans exactly 4096 strobes. `cal_busy` stays high through the 4095th and is low after the 4096th. Every output sample in that span is zero.
- R6: The first strobe after calibration completes yields zero data with `mute` still high. `mute` is low after that strobe, and the next strobe yields valid data.
- R7: The offset of each channel is the floor of the sum of its 4096 calibration samples divided by 4096. In normal running, the output is the sample minus that channel's offset. Lane k occupies bits [20k+19:20k] of `smp_in` and `smp_out`; lane 0 is bits 19:0.
- R8: A corrected value above 524287 is output as 524287 (0x7FFFF). A value below -524288 is output as -524288 (0x80000). Values exactly on these limits pass unchanged.
- R9: While `cal_en_n` is high, releasing `pdn_n` starts no calibration and the stored offsets are not subtracted. When `cal_en_n` is low again, the stored offsets are subtracted again.
- R10: If `pdn_n` goes low during a calibration, including in the cycle of its final strobe, the calibration is abandoned. The previous offsets are kept and the block enters power-down.
- R11: `out_vld` pulses high exactly one clock after each `smp_stb`, whatever the mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| pdn_n | input | 1 | Power-down request, active low; its release launches calibration |
| cal_en_n | input | 1 | Calibration enable, active low |
| smp_stb | input | 1 | One-cycle pulse per sample period |
| smp_in | input | 40 | Input samples, lane 0 in bits 19:0, lane 1 in bits 39:20 |
| smp_out | output | 40 | Corrected samples, same lane layout |
| out_vld | output | 1 | Output data valid, one clock after each strobe |
| cal_busy | output | 1 | High while a calibration is running |
| mute | output | 1 | Quiet request to the serial transmitter |
| pwr_down | output | 1 | High while in power-down |

## Verification
The delicate coincidence is the power-down input falling in the same cycle as the 4096th calibration strobe, the one that would otherwise commit the new averages. The bench drives both in one cycle. It then checks that `cal_busy` drops with `pwr_down` high. It returns to normal running through a release with calibration disabled, re-enables calibration, and confirms that later corrected samples still use the offsets of the previous completed calibration. A second coincidence, a strobe in the cycle that power-down is entered, is judged by the scoreboard to yield corrected data rather than silence.

// File: rtl/ofc_pkg.sv
package ofc_pkg;
  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_PDOWN  = 2'd1,
    ST_CAL    = 2'd2,
    ST_RESUME = 2'd3
  } ofc_state_e;
endpackage

// File: rtl/ofc_pulse_qual.sv
// Counts consecutive low samples of the power-down input and flags a
// qualified release (low for more than QUAL_CLKS edges, now high).
module ofc_pulse_qual #(
  parameter int QUAL_CLKS = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pdn_n,
  output logic rel_ok
);
  localparam int CW = $clog2(QUAL_CLKS + 2);
  localparam logic [CW-1:0] CNT_TOP = CW'(QUAL_CLKS + 1);

  logic [CW-1:0] low_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      low_cnt <= '0;
    end else if (!pdn_n) begin
      if (low_cnt != CNT_TOP) low_cnt <= low_cnt + 1'b1;
    end else begin
      low_cnt <= '0;
    end
  end

  assign rel_ok = pdn_n && (low_cnt == CNT_TOP);
endmodule

// File: rtl/ofc_seq.sv
// Mode sequencer: run, power-down, calibration window, resume gap.
module ofc_seq
  import ofc_pkg::*;
#(
  parameter int CAL_LOG2 = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic pdn_n,
  input  logic cal_en_n,
  input  logic smp_stb,
  input  logic rel_ok,
  output logic run,
  output logic acc_clr,
  output logic acc_en,
  output logic cal_done,
  output logic cal_busy,
  output logic mute,
  output logic pwr_down
);
  localparam logic [CAL_LOG2-1:0] LAST_IDX = {CAL_LOG2{1'b1}};

  ofc_state_e state, nxt;
  logic [CAL_LOG2-1:0] scnt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_RUN:    if (!pdn_n) nxt = ST_PDOWN;
      ST_PDOWN:  if (pdn_n) nxt = (rel_ok && !cal_en_n) ? ST_CAL : ST_RUN;
      ST_CAL: begin
        if (!pdn_n)                             nxt = ST_PDOWN;
        else if (smp_stb && scnt == LAST_IDX)   nxt = ST_RESUME;
      end
      ST_RESUME: begin
        if (!pdn_n)        nxt = ST_PDOWN;
        else if (smp_stb)  nxt = ST_RUN;
      end
      default: nxt = ST_RUN;
    endcase
  end

  assign run      = (state == ST_RUN);
  assign acc_clr  = (nxt == ST_CAL) && (state != ST_CAL);
  assign acc_en   = (state == ST_CAL) && smp_stb;
  assign cal_done = (state == ST_CAL) && (nxt == ST_RESUME);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_RUN;
      scnt     <= '0;
      cal_busy <= 1'b0;
      mute     <= 1'b0;
      pwr_down <= 1'b0;
    end else begin
      state    <= nxt;
      if (acc_clr)     scnt <= '0;
      else if (acc_en) scnt <= scnt + 1'b1;
      cal_busy <= (nxt == ST_CAL);
      mute     <= (nxt != ST_RUN);
      pwr_down <= (nxt == ST_PDOWN);
    end
  end

  // R2
  pd_enter_chk: assert property (@(posedge clk) disable iff (rst)
    !pdn_n |=> (pwr_down && mute && !cal_busy));
  // R3
  short_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PDOWN && pdn_n && !rel_ok) |=> !cal_busy);
  // R4
  cal_start_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PDOWN && rel_ok && !cal_en_n) |=> (cal_busy && mute));
  // R5
  cal_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cal_busy && !smp_stb && pdn_n) |=> cal_busy);
  // R9
  cal_off_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PDOWN && pdn_n && cal_en_n) |=> !cal_busy);
endmodule

// File: rtl/ofc_lane.sv
// One channel: calibration accumulator, offset register, subtract and clamp.
module ofc_lane #(
  parameter int DW       = 20,
  parameter int ACC_W    = 32,
  parameter int CAL_LOG2 = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] din,
  input  logic          stb,
  input  logic          run,
  input  logic          apply,
  input  logic          acc_clr,
  input  logic          acc_en,
  input  logic          cal_done,
  output logic [DW-1:0] dout
);
  localparam logic [DW-1:0] POS_LIM = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] NEG_LIM = {1'b1, {(DW-1){1'b0}}};

  logic signed [ACC_W-1:0] acc, din_x, acc_sum;
  logic signed [DW-1:0]    ofs, ofs_eff;
  logic signed [DW:0]      diff;
  logic [DW-1:0]           clamped;

  assign din_x   = {{(ACC_W-DW){din[DW-1]}}, din};
  assign acc_sum = acc + din_x;

  always_ff @(posedge clk) begin
    if (rst)          acc <= '0;
    else if (acc_clr) acc <= '0;
    else if (acc_en)  acc <= acc_sum;
  end

  always_ff @(posedge clk) begin
    if (rst)           ofs <= '0;
    else if (cal_done) ofs <= DW'(acc_sum >>> CAL_LOG2);
  end

  assign ofs_eff = apply ? ofs : '0;

  always_comb begin
    diff = $signed({din[DW-1], din}) - $signed({ofs_eff[DW-1], ofs_eff});
    if (diff[DW] != diff[DW-1]) clamped = diff[DW] ? NEG_LIM : POS_LIM;
    else                        clamped = diff[DW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)      dout <= '0;
    else if (stb) dout <= run ? clamped : '0;
  end
endmodule

// File: rtl/ofc_cal_seq.sv
module ofc_cal_seq #(
  parameter int NCH       = 2,
  parameter int DW        = 20,
  parameter int ACC_W     = 32,
  parameter int CAL_LOG2  = 12,
  parameter int QUAL_CLKS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pdn_n,
  input  logic              cal_en_n,
  input  logic              smp_stb,
  input  logic [NCH*DW-1:0] smp_in,
  output logic [NCH*DW-1:0] smp_out,
  output logic              out_vld,
  output logic              cal_busy,
  output logic              mute,
  output logic              pwr_down
);
  logic rel_ok, run, acc_clr, acc_en, cal_done;

  ofc_pulse_qual #(.QUAL_CLKS(QUAL_CLKS)) u_qual (
    .clk(clk), .rst(rst), .pdn_n(pdn_n), .rel_ok(rel_ok)
  );

  ofc_seq #(.CAL_LOG2(CAL_LOG2)) u_seq (
    .clk(clk), .rst(rst), .pdn_n(pdn_n), .cal_en_n(cal_en_n),
    .smp_stb(smp_stb), .rel_ok(rel_ok), .run(run),
    .acc_clr(acc_clr), .acc_en(acc_en), .cal_done(cal_done),
    .cal_busy(cal_busy), .mute(mute), .pwr_down(pwr_down)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_lane
    ofc_lane #(.DW(DW), .ACC_W(ACC_W), .CAL_LOG2(CAL_LOG2)) u_lane (
      .clk(clk), .rst(rst), .din(smp_in[g*DW +: DW]), .stb(smp_stb),
      .run(run), .apply(!cal_en_n), .acc_clr(acc_clr), .acc_en(acc_en),
      .cal_done(cal_done), .dout(smp_out[g*DW +: DW])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) out_vld <= 1'b0;
    else     out_vld <= smp_stb;
  end

  // R5
  quiet_cal_chk: assert property (@(posedge clk) disable iff (rst)
    (cal_busy && out_vld) |-> (smp_out == '0));
  // R11
  vld_follow_chk: assert property (@(posedge clk) disable iff (rst)
    smp_stb |=> out_vld);
endmodule

// File: tb/ofc_cal_seq_test.sv
module ofc_cal_seq_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pdn_n = 1'b1;
  logic cal_en_n = 1'b0;
  logic smp_stb = 1'b0;
  logic [39:0] smp_in = '0;
  logic [39:0] smp_out;
  logic out_vld, cal_busy, mute, pwr_down;

  int n_tot = 0;
  int n_bad = 0;
  bit done = 0;
  int ofs_l = 0, ofs_r = 0;

  logic [39:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  ofc_cal_seq uut (
    .clk(clk), .rst(rst), .pdn_n(pdn_n), .cal_en_n(cal_en_n),
    .smp_stb(smp_stb), .smp_in(smp_in), .smp_out(smp_out),
    .out_vld(out_vld), .cal_busy(cal_busy), .mute(mute), .pwr_down(pwr_down)
  );

  task automatic chk(bit ok, string tag, int act, int expv);
    n_tot++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic logic [19:0] model(int x, int o);
    int d;
    d = x - o;
    if (d > 524287) d = 524287;
    if (d < -524288) d = -524288;
    return d[19:0];
  endfunction

  task automatic push_exp(int l, int r, bit quiet, string tag);
    logic [19:0] el, er;
    el = quiet ? 20'd0 : model(l, cal_en_n ? 0 : ofs_l);
    er = quiet ? 20'd0 : model(r, cal_en_n ? 0 : ofs_r);
    exp_q.push_back({er, el});
    tag_q.push_back(tag);
  endtask

  // driver: one strobe per 4 clocks
  task automatic send(int l, int r, bit quiet, string tag);
    @(posedge clk); #1;
    smp_stb = 1'b1;
    smp_in = {r[19:0], l[19:0]};
    push_exp(l, r, quiet, tag);
    @(posedge clk); #1;
    smp_stb = 1'b0;
    repeat (2) @(posedge clk);
  endtask

  task automatic pd_pulse(int edges);
    @(posedge clk); #1;
    pdn_n = 1'b0;
    repeat (edges) @(posedge clk);
    #1 pdn_n = 1'b1;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && out_vld) begin
      if (exp_q.size() == 0) begin
        chk(0, "R11 unexpected out_vld", 1, 0);
      end else begin
        logic [39:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(smp_out[19:0] == e[19:0], {t, " lane0"},
            int'($signed(smp_out[19:0])), int'($signed(e[19:0])));
        chk(smp_out[39:20] == e[39:20], {t, " lane1"},
            int'($signed(smp_out[39:20])), int'($signed(e[39:20])));
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_tot - n_bad, n_tot);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tot++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  // runs one calibration with a ramp pattern; returns after the last strobe
  task automatic cal_samples(int bl, int br, int count, output longint sl, output longint sr);
    sl = 0; sr = 0;
    for (int i = 0; i < count; i++) begin
      send(bl + (i & 3), br + (i & 3), 1'b1, "R5 cal quiet");
      sl += bl + (i & 3);
      sr += br + (i & 3);
      if (i == 4094) chk(cal_busy == 1'b1, "R5 busy before last", int'(cal_busy), 1);
    end
  endtask

  initial begin
    longint sl, sr;
    bit seen;
    // R1 reset state
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk({out_vld, cal_busy, mute, pwr_down} == 4'b0, "R1 flags in reset",
        int'({out_vld, cal_busy, mute, pwr_down}), 0);
    chk(smp_out == '0, "R1 data in reset", int'(smp_out[19:0]), 0);
    @(posedge clk); #1 rst = 1'b0;
    @(negedge clk);
    chk({out_vld, cal_busy, mute, pwr_down} == 4'b0, "R1 flags after reset",
        int'({out_vld, cal_busy, mute, pwr_down}), 0);

    // R7 R11 pass-through with zero offsets, lane order
    send(123, -456, 0, "R7 zero offset");
    send(524287, -524288, 0, "R8 limits zero offset");
    send(-1, 1, 0, "R11 lane order");

    // R2 power-down with a strobe on the entry cycle
    @(posedge clk); #1;
    pdn_n = 1'b0; smp_stb = 1'b1; smp_in = {20'(-7), 20'd9};
    push_exp(9, -7, 0, "R2 strobe on entry cycle");
    @(posedge clk); #1 smp_stb = 1'b0;
    @(negedge clk);
    chk(pwr_down && mute && !cal_busy, "R2 flags in power-down",
        int'({pwr_down, mute, cal_busy}), 6);
    send(3000, 4000, 1, "R2 quiet in power-down");
    // R9 release with calibration disabled
    cal_en_n = 1'b1;
    @(posedge clk); #1 pdn_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!cal_busy && !mute && !pwr_down, "R9 no cal when disabled",
        int'({pwr_down, mute, cal_busy}), 0);
    send(55, 66, 0, "R9 pass after release");
    cal_en_n = 1'b0;

    // R3 short pulse ignored
    pd_pulse(2);
    seen = 0;
    repeat (8) begin
      @(negedge clk);
      if (cal_busy) seen = 1;
    end
    chk(!seen, "R3 short pulse no cal", int'(seen), 0);
    send(10, 20, 0, "R3 data flows after short pulse");

    // R4 R5 R6 R7 calibration
    pd_pulse(3);
    repeat (2) @(negedge clk);
    chk(cal_busy && mute, "R4 cal start", int'({cal_busy, mute}), 3);
    cal_samples(1000, -2000, 4096, sl, sr);
    @(negedge clk);
    chk(!cal_busy && mute, "R5 busy low after last, R6 still muted",
        int'({cal_busy, mute}), 1);
    ofs_l = int'(sl >>> 12);
    ofs_r = int'(sr >>> 12);
    send(5, 5, 1, "R6 resume gap quiet");
    @(negedge clk);
    chk(!mute, "R6 mute released", int'(mute), 0);
    send(2000, -3000, 0, "R7 corrected");
    send(0, 0, 0, "R7 zero input");
    // R8 saturation and exact limits
    send(-524000, 524000, 0, "R8 clamp");
    send(-523287, 522288, 0, "R8 exact limits");
    // R9 offset bypass and re-apply
    cal_en_n = 1'b1;
    send(777, -777, 0, "R9 offsets bypassed");
    cal_en_n = 1'b0;
    send(777, -777, 0, "R9 offsets re-applied");

    // R10 abort on final strobe
    pd_pulse(4);
    repeat (2) @(negedge clk);
    chk(cal_busy, "R4 second cal start", int'(cal_busy), 1);
    cal_samples(50, 50, 4095, sl, sr);
    @(posedge clk); #1;
    smp_stb = 1'b1; pdn_n = 1'b0; smp_in = {20'd53, 20'd53};
    push_exp(53, 53, 1, "R10 final strobe quiet");
    @(posedge clk); #1 smp_stb = 1'b0;
    @(negedge clk);
    chk(!cal_busy && pwr_down, "R10 abort to power-down",
        int'({cal_busy, pwr_down}), 1);
    repeat (3) @(posedge clk);
    #1 cal_en_n = 1'b1;
    @(posedge clk); #1 pdn_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!cal_busy && !mute, "R10 back to run", int'({cal_busy, mute}), 0);
    cal_en_n = 1'b0;
    send(2000, -3000, 0, "R10 old offsets kept");

    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(exp_q.size() == 0, "R11 all outputs seen", exp_q.size(), 0);
    finish_run();
  end
endmodule